// File: doc/BRIEF.md
# Temperature Conversion Sequencer and Result Register

This block sits between a temperature converter and the register file of a sensor. It decides when conversions run and owns the 16-bit temperature result that the bus reads. With the shutdown bit clear, it runs back to back: each completed conversion launches the next one on the following cycle. With the shutdown bit set, it stays idle. A conversion already in flight when shutdown is requested still finishes and lands in the result register. In shutdown, a single conversion can be requested through the one-shot bit. When that conversion completes, the block asks the configuration register to clear the bit and goes back to idle.

Each result arrives as a 17-bit signed raw value with 1/256 °C per LSB. The block stores it either in plain two's complement or in an extended form offset by 64 °C, and saturates it into 16 bits. The format is sampled when a conversion starts, so a format change first shows on the result of the conversion that begins after the change. While the bus is reading the temperature register, the visible value is frozen. Only the newest result that arrives during the read is kept, and it is loaded once the read ends. The done pulse comes either from an external converter model or, when the block is built for that variant, from an internal tick counter that models the conversion time.

Top module: `tconv_ctrl`

## Requirements
- R1: During reset `temp_reg` is 0000h and `conv_start` and `oneshot_clr` are 0. With `cfg_shutdown` low, `conv_start` pulses in the first cycle after reset is released.
- R2: With `cfg_shutdown` low, a `conv_done` pulse during a conversion makes `conv_start` pulse high for one cycle in the next cycle.
- R3: If `cfg_shutdown` is high when the running conversion's `conv_done` arrives, that result is still stored. No further `conv_start` follows while `cfg_shutdown` stays high.
- R4: While idle in shutdown, `cfg_shutdown` sampled low gives a `conv_start` pulse in the next cycle.
- R5: While idle in shutdown, `cfg_wr` with `cfg_oneshot` high starts one conversion with `conv_start` in the next cycle. When that conversion's `conv_done` arrives, `oneshot_clr` pulses for one cycle, together with the result update, and no new conversion starts.
- R6: `cfg_wr` with `cfg_oneshot` high while a conversion is running produces no extra `conv_start`. It also produces no `oneshot_clr` when that conversion completes.
- R7: With the plain format (`cfg_extfmt` = 0), the stored value is the raw value saturated to the range 8000h to 7FFFh. For example, raw 08000h gives 7FFFh and raw 1E700h gives E700h.
- R8: With the extended format (`cfg_extfmt` = 1), the stored value is the raw value minus 4000h, saturated to 16 bits. For example, raw 09600h gives 5600h and raw 1BB00h gives 8000h.
- R9: The format used for a result is the value of `cfg_extfmt` when that conversion started.
- R10: From the cycle after `rd_start` until `rd_end`, `temp_reg` does not change.
- R11: On `rd_end`, the newest result that arrived during the read appears on `temp_reg` in the next cycle. If none arrived, `temp_reg` keeps its value.
- R12: A `conv_done` pulse while idle in shutdown is ignored and leaves `temp_reg` unchanged.
- R13: Any new result appears on `temp_reg` in the cycle after its `conv_done` pulse, unless a read is holding the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_shutdown | input | 1 | Shutdown bit (level) |
| cfg_oneshot | input | 1 | One-shot bit, acted on with `cfg_wr` |
| cfg_extfmt | input | 1 | Extended data format select |
| adc_done | input | 1 | Conversion complete pulse from the converter model |
| adc_raw | input | 17 | Signed raw result, 1/256 °C per LSB |
| rd_start | input | 1 | Bus read of the temperature register begins |
| rd_end | input | 1 | Bus read of the temperature register ends |
| conv_start | output | 1 | One-cycle conversion start pulse |
| oneshot_clr | output | 1 | One-cycle request to clear the one-shot bit |
| temp_reg | output | 16 | Visible temperature result |

## Verification
Three kinds of internal fault show up at the ports. A sequencer stuck in the wrong state shows within one cycle of the next `conv_done` or configuration change, either as a missing or extra `conv_start` or as a wrong `oneshot_clr`. A wrong format latch or a wrong saturation limit shows on `temp_reg` in the cycle after the `conv_done` that used it. Faults in the read-hold path cause one of two things:
- a change on `temp_reg` during a read, or
- a stale or older value in the cycle after `rd_end`.

For these reasons, the reference model is compared against all three outputs on every cycle.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tconv_timer.sv
module tconv_timer #(
  parameter int unsigned CONV_TICKS = 2200000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(CONV_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt_q <= CNT_W'(CONV_TICKS - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tconv_fmt.sv
module tconv_fmt #(
  parameter int DATA_W = 16,
  parameter int RAW_W  = DATA_W + 1
) (
  input  logic [RAW_W-1:0]  raw,
  input  logic              ext,
  output logic [DATA_W-1:0] value
);
  localparam int SUM_W = RAW_W + 1;
  localparam logic signed [SUM_W-1:0] OFFS = SUM_W'(1) << (DATA_W - 2);
  localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) << (DATA_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

  logic signed [SUM_W-1:0] shifted;

  always_comb begin
    shifted = $signed({raw[RAW_W-1], raw}) - (ext ? OFFS : '0);
    if (shifted > MAXV)      value = {1'b0, {(DATA_W-1){1'b1}}};
    else if (shifted < MINV) value = {1'b1, {(DATA_W-1){1'b0}}};
    else                     value = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
  import tconv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_shutdown,
  input  logic cfg_oneshot,
  input  logic cfg_extfmt,
  input  logic conv_done,
  output logic conv_start,
  output logic oneshot_clr,
  output logic fmt_q,
  output logic res_take,
  output logic in_idle
);
  seq_state_e state_q;
  logic       os_run_q;

  always_comb begin
    res_take = (state_q == ST_CONV) && conv_done;
    in_idle  = (state_q == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      os_run_q    <= 1'b0;
      fmt_q       <= 1'b0;
      conv_start  <= 1'b0;
      oneshot_clr <= 1'b0;
    end else begin
      conv_start  <= 1'b0;
      oneshot_clr <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (!cfg_shutdown) begin
            state_q    <= ST_CONV;
            conv_start <= 1'b1;
            os_run_q   <= 1'b0;
            fmt_q      <= cfg_extfmt;
          end else if (cfg_wr && cfg_oneshot) begin
            state_q    <= ST_CONV;
            conv_start <= 1'b1;
            os_run_q   <= 1'b1;
            fmt_q      <= cfg_extfmt;
          end
        end
        default: begin
          if (conv_done) begin
            oneshot_clr <= os_run_q;
            os_run_q    <= 1'b0;
            if (cfg_shutdown) begin
              state_q <= ST_IDLE;
            end else begin
              conv_start <= 1'b1;
              fmt_q      <= cfg_extfmt;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tconv_hold.sv
module tconv_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_start,
  input  logic              rd_end,
  input  logic              take,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] temp_q,
  output logic              reading_q
);
  logic [DATA_W-1:0] pend_q;
  logic              pend_v_q;
  logic              hold;

  always_comb hold = (reading_q && !rd_end) || rd_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q    <= '0;
      pend_q    <= '0;
      pend_v_q  <= 1'b0;
      reading_q <= 1'b0;
    end else begin
      if (rd_start)    reading_q <= 1'b1;
      else if (rd_end) reading_q <= 1'b0;

      if (take) begin
        if (hold) begin
          pend_q   <= value;
          pend_v_q <= 1'b1;
        end else begin
          temp_q   <= value;
          pend_v_q <= 1'b0;
        end
      end else if (!hold && pend_v_q) begin
        temp_q   <= pend_q;
        pend_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl #(
  parameter int          DATA_W     = 16,
  parameter bit          EXT_DONE   = 1'b1,
  parameter int unsigned CONV_TICKS = 2200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_shutdown,
  input  logic              cfg_oneshot,
  input  logic              cfg_extfmt,
  input  logic              adc_done,
  input  logic [DATA_W:0]   adc_raw,
  input  logic              rd_start,
  input  logic              rd_end,
  output logic              conv_start,
  output logic              oneshot_clr,
  output logic [DATA_W-1:0] temp_reg
);
  localparam int RAW_W = DATA_W + 1;

  logic              conv_done;
  logic              fmt_cur;
  logic              res_take;
  logic              in_idle;
  logic              reading;
  logic [DATA_W-1:0] fmt_value;

  generate
    if (EXT_DONE) begin : g_ext_done
      assign conv_done = adc_done;
    end else begin : g_int_done
      tconv_timer #(.CONV_TICKS(CONV_TICKS)) u_timer (
        .clk(clk), .rst(rst), .start(conv_start), .done(conv_done)
      );
    end
  endgenerate

  tconv_seq u_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_shutdown(cfg_shutdown),
    .cfg_oneshot(cfg_oneshot), .cfg_extfmt(cfg_extfmt), .conv_done(conv_done),
    .conv_start(conv_start), .oneshot_clr(oneshot_clr), .fmt_q(fmt_cur),
    .res_take(res_take), .in_idle(in_idle)
  );

  tconv_fmt #(.DATA_W(DATA_W), .RAW_W(RAW_W)) u_fmt (
    .raw(adc_raw), .ext(fmt_cur), .value(fmt_value)
  );

  tconv_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .rd_start(rd_start), .rd_end(rd_end),
    .take(res_take), .value(fmt_value), .temp_q(temp_reg), .reading_q(reading)
  );
endmodule

// File: rtl/tconv_ctrl_chk.sv
module tconv_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              cfg_shutdown,
  input logic              cfg_oneshot,
  input logic              conv_done,
  input logic              rd_start,
  input logic              rd_end,
  input logic              conv_start,
  input logic              oneshot_clr,
  input logic [DATA_W-1:0] temp_reg,
  input logic              in_idle,
  input logic              reading
);
  AST_RESTART_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (!in_idle && conv_done && !cfg_shutdown) |=> conv_start); // R2
  AST_SHUTDOWN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!in_idle && conv_done && cfg_shutdown) |=> !conv_start); // R3
  AST_WAKE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !cfg_shutdown) |=> conv_start); // R4
  AST_CLEAR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    oneshot_clr |-> $past(conv_done)); // R5
  AST_ONESHOT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!in_idle && cfg_wr && cfg_oneshot && !conv_done) |=> !conv_start); // R6
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (rd_start || (reading && !rd_end)) |=> $stable(temp_reg)); // R10
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (in_idle && conv_done && !reading && !rd_start && !rd_end && $stable(temp_reg))
      |=> $stable(temp_reg)); // R12
endmodule

bind tconv_ctrl tconv_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_shutdown(cfg_shutdown),
  .cfg_oneshot(cfg_oneshot), .conv_done(conv_done), .rd_start(rd_start),
  .rd_end(rd_end), .conv_start(conv_start), .oneshot_clr(oneshot_clr),
  .temp_reg(temp_reg), .in_idle(in_idle), .reading(reading)
);

// File: tb/tb_tconv_ctrl.sv
module tb_tconv_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_shutdown = 0, cfg_oneshot = 0, cfg_extfmt = 0;
  logic        adc_done = 0;
  logic [16:0] adc_raw = '0;
  logic        rd_start = 0, rd_end = 0;
  logic        conv_start, oneshot_clr;
  logic [15:0] temp_reg;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #10 clk = ~clk;

  tconv_ctrl dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_shutdown(cfg_shutdown),
    .cfg_oneshot(cfg_oneshot), .cfg_extfmt(cfg_extfmt), .adc_done(adc_done),
    .adc_raw(adc_raw), .rd_start(rd_start), .rd_end(rd_end),
    .conv_start(conv_start), .oneshot_clr(oneshot_clr), .temp_reg(temp_reg)
  );

  // Behavioural reference model
  bit m_idle = 1, m_os = 0, m_fmt = 0, m_read = 0, m_pv = 0;
  bit m_cs = 0, m_oc = 0;
  int m_temp = 0, m_pend = 0;

  function automatic int fmt_ref(int raw, bit ext);
    int v;
    v = ext ? raw - 16384 : raw;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v & 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    bit got, hold;
    int res;
    got = 0; res = 0;
    if (rst) begin
      m_idle = 1; m_os = 0; m_fmt = 0; m_read = 0; m_pv = 0;
      m_cs = 0; m_oc = 0; m_temp = 0; m_pend = 0;
    end else begin
      m_cs = 0; m_oc = 0;
      if (m_idle) begin
        if (!cfg_shutdown) begin
          m_cs = 1; m_idle = 0; m_os = 0; m_fmt = cfg_extfmt;
        end else if (cfg_wr && cfg_oneshot) begin
          m_cs = 1; m_idle = 0; m_os = 1; m_fmt = cfg_extfmt;
        end
      end else if (adc_done) begin
        res = fmt_ref(int'($signed(adc_raw)), m_fmt);
        got = 1;
        m_oc = m_os; m_os = 0;
        if (cfg_shutdown) m_idle = 1;
        else begin m_cs = 1; m_fmt = cfg_extfmt; end
      end
      hold = (m_read && !rd_end) || rd_start;
      if (got) begin
        if (hold) begin m_pend = res; m_pv = 1; end
        else begin m_temp = res; m_pv = 0; end
      end else if (!hold && m_pv) begin
        m_temp = m_pend; m_pv = 0;
      end
      if (rd_start) m_read = 1;
      else if (rd_end) m_read = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(cur_req, "conv_start", int'(conv_start), int'(m_cs));
      chk(cur_req, "oneshot_clr", int'(oneshot_clr), int'(m_oc));
      chk(cur_req, "temp_reg", int'(temp_reg), m_temp);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic done_pulse(logic [16:0] raw);
    adc_done = 1; adc_raw = raw;
    step();
    adc_done = 0;
  endtask

  task automatic cfg_write(bit sd, bit os, bit ext);
    cfg_shutdown = sd; cfg_oneshot = os; cfg_extfmt = ext; cfg_wr = 1;
    step();
    cfg_wr = 0; cfg_oneshot = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R1", "reset temp", int'(temp_reg), 0);
    chk("R1", "reset start", int'(conv_start), 0);
    rst = 0;
    step();
    chk("R1", "first start", int'(conv_start), 1);
    repeat (3) step();

    cur_req = "R2";
    done_pulse(17'h01900);
    chk("R13", "plain 25C", int'(temp_reg), 16'h1900);
    chk("R2", "restart", int'(conv_start), 1);
    step();
    cur_req = "R7";
    done_pulse(17'h08000);
    chk("R7", "sat high", int'(temp_reg), 16'h7FFF);
    done_pulse(17'h1E700);
    chk("R7", "minus 25C", int'(temp_reg), 16'hE700);
    step();

    cur_req = "R9";
    cfg_write(0, 0, 1);
    done_pulse(17'h01900);
    chk("R9", "old format kept", int'(temp_reg), 16'h1900);
    cur_req = "R8";
    done_pulse(17'h09600);
    chk("R8", "ext 150C", int'(temp_reg), 16'h5600);
    done_pulse(17'h1C900);
    chk("R8", "ext minus 55C", int'(temp_reg), 16'h8900);
    done_pulse(17'h1BB00);
    chk("R8", "ext sat low", int'(temp_reg), 16'h8000);
    cur_req = "R9";
    cfg_write(0, 0, 0);
    done_pulse(17'h00080);
    chk("R9", "ext until next", int'(temp_reg), 16'hC080);
    done_pulse(17'h00080);
    chk("R9", "plain again", int'(temp_reg), 16'h0080);

    cur_req = "R10";
    rd_start = 1; step(); rd_start = 0;
    done_pulse(17'h02000);
    chk("R10", "frozen 1", int'(temp_reg), 16'h0080);
    step();
    done_pulse(17'h02100);
    chk("R10", "frozen 2", int'(temp_reg), 16'h0080);
    cur_req = "R11";
    rd_end = 1; step(); rd_end = 0;
    chk("R11", "newest loaded", int'(temp_reg), 16'h2100);
    rd_start = 1; step(); rd_start = 0;
    step();
    rd_end = 1; step(); rd_end = 0;
    step();
    chk("R11", "no pending", int'(temp_reg), 16'h2100);

    cur_req = "R3";
    cfg_write(1, 0, 0);
    step();
    done_pulse(17'h01000);
    chk("R3", "last result", int'(temp_reg), 16'h1000);
    chk("R3", "no restart", int'(conv_start), 0);
    repeat (4) step();
    chk("R3", "still idle", int'(conv_start), 0);

    cur_req = "R12";
    done_pulse(17'h01100);
    chk("R12", "idle done ignored", int'(temp_reg), 16'h1000);

    cur_req = "R5";
    cfg_write(1, 1, 0);
    chk("R5", "oneshot start", int'(conv_start), 1);
    repeat (2) step();
    done_pulse(17'h01200);
    chk("R5", "oneshot result", int'(temp_reg), 16'h1200);
    chk("R5", "oneshot clear", int'(oneshot_clr), 1);
    chk("R5", "back to idle", int'(conv_start), 0);
    step();
    chk("R5", "clear one cycle", int'(oneshot_clr), 0);

    cur_req = "R4";
    cfg_write(0, 0, 0);
    chk("R4", "wake start", int'(conv_start), 1);
    step();

    cur_req = "R6";
    cfg_write(0, 1, 0);
    chk("R6", "no extra start", int'(conv_start), 0);
    step();
    done_pulse(17'h01300);
    chk("R6", "no clear", int'(oneshot_clr), 0);
    chk("R6", "normal restart", int'(conv_start), 1);
    repeat (3) step();
    finish_run();
  end
endmodule